// File: doc/BRIEF.md
# Branch Delay Slot Fetch Sequencer

This block owns the fetch address of a classic five-stage RISC pipeline that has one architectural branch delay slot. Every cycle it presents an address to a synchronous instruction memory, and one clock later it receives the word at that address. It decodes the word for control transfers: conditional branches on equal or not-equal, the absolute jump, and the register jump. The register-file compare result and the source register value come in from outside the block.

A taken transfer does not cancel the instruction that was fetched behind it. That word is already in flight when the transfer is decoded, so it is the delay slot and it always runs. The redirect reaches the fetch address one fetch later. Branch offsets are measured from the delay-slot address. The sequencer flags the delay-slot instruction so the rest of the pipeline can see it. A control transfer that sits inside a delay slot is not supported, so the block raises an error pulse and drops that transfer's redirect. The block also marks the instruction that follows a load, because no forwarding is provided into that slot. A stall input freezes all sequencing state.

Top module: `delay_slot_sequencer`

## Requirements
- R1: While reset is held, fetch_addr equals the RESET_ADDR parameter (default 0x00000000) and redirect, slot_error, decode_in_slot and load_shadow are all 0.
- R2: With no redirect and no stall, fetch_addr increases by 4 on each clock.
- R3: A word with bits 31:26 = 000100 (equal-branch) is taken when rs_equal is 1. Its target is (decode address + 4) + sign-extended bits 15:0 times 4. When rs_equal is 0 the branch is not taken and sequential fetch continues.
- R4: A word with bits 31:26 = 000101 (not-equal-branch) is taken when rs_equal is 0 and uses the same target rule. For example, 0x1500fff7 decoded at 0x0040002c sends fetch to 0x0040000c.
- R5: The word fetched right after any decoded transfer, taken or not, is decoded next with decode_in_slot = 1. When the transfer is taken, fetch_addr shows the target on the clock after redirect is high.
- R6: A word with bits 31:26 = 000010 jumps to {(decode address + 4)[31:28], bits 25:0, 2'b00}.
- R7: A word with bits 31:26 = 000000 and bits 5:0 = 001000 jumps to rs_value, which is the return path through the link register.
- R8: While stall is 1, fetch_addr, decode_addr and the flags hold their values and redirect is 0. A transfer that was pending takes effect once stall drops.
- R9: A transfer decoded in a delay slot raises slot_error for that cycle and produces no redirect. Fetch continues sequentially from the slot.
- R10: The instruction decoded right after a load (bits 31:29 = 100) has load_shadow = 1. Every other instruction has load_shadow = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freezes all sequencing state |
| instr_word | input | 32 | Word returned by instruction memory for the previous fetch_addr |
| rs_equal | input | 1 | Register compare result for the decoded branch |
| rs_value | input | 32 | Source register value for the register jump |
| fetch_addr | output | 32 | Address sent to instruction memory |
| decode_addr | output | 32 | Address of the word now on instr_word |
| decode_in_slot | output | 1 | Decoded word is a delay slot |
| redirect | output | 1 | Decoded transfer is taken this cycle |
| slot_error | output | 1 | Transfer found inside a delay slot |
| load_shadow | output | 1 | Decoded word follows a load |

## Verification
The decode-stage outputs (redirect, slot_error, decode_in_slot, load_shadow) describe the word fetched one clock earlier. A branch's target appears on fetch_addr one clock after its redirect, which is two clocks after the branch address was fetched. The bench advances one rising edge at a time and samples at the following falling edge. Each expected address is written against the step number at which it becomes due, counting from reset release, and the bench's memory model adds one register of read latency that matches the synchronous port.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  localparam int WORD_W = 32;
  localparam logic [5:0] OP_SPECIAL = 6'b000000;
  localparam logic [5:0] OP_JUMP    = 6'b000010;
  localparam logic [5:0] OP_BR_EQ   = 6'b000100;
  localparam logic [5:0] OP_BR_NE   = 6'b000101;
  localparam logic [5:0] FN_REGJMP  = 6'b001000;
  localparam logic [2:0] OP_LOADGRP = 3'b100;

  typedef enum logic [2:0] {CF_NONE, CF_BEQ, CF_BNE, CF_J, CF_JR} cf_kind_t;

  typedef struct packed {
    cf_kind_t    kind;
    logic        is_load;
    logic [15:0] offs;
    logic [25:0] index;
  } dec_t;

  function automatic dec_t decode_word(input logic [WORD_W-1:0] w);
    dec_t d;
    d.offs    = w[15:0];
    d.index   = w[25:0];
    d.is_load = (w[31:29] == OP_LOADGRP);
    case (w[31:26])
      OP_BR_EQ:   d.kind = CF_BEQ;
      OP_BR_NE:   d.kind = CF_BNE;
      OP_JUMP:    d.kind = CF_J;
      OP_SPECIAL: d.kind = (w[5:0] == FN_REGJMP) ? CF_JR : CF_NONE;
      default:    d.kind = CF_NONE;
    endcase
    return d;
  endfunction

  function automatic logic [WORD_W-1:0] branch_dest(input logic [WORD_W-1:0] slot,
                                                    input logic [15:0] offs);
    return slot + {{(WORD_W-18){offs[15]}}, offs, 2'b00};
  endfunction

  function automatic logic [WORD_W-1:0] jump_dest(input logic [WORD_W-1:0] slot,
                                                  input logic [25:0] index);
    return {slot[WORD_W-1:WORD_W-4], index, 2'b00};
  endfunction
endpackage

// File: rtl/pcseq_decode.sv
module pcseq_decode
  import pcseq_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output dec_t              dec
);
  always_comb dec = decode_word(word);
endmodule

// File: rtl/pcseq_target.sv
module pcseq_target
  import pcseq_pkg::*;
(
  input  dec_t              dec,
  input  logic              eq,
  input  logic [WORD_W-1:0] reg_val,
  input  logic [WORD_W-1:0] slot_addr,
  output logic              take,
  output logic [WORD_W-1:0] dest
);
  always_comb begin
    take = 1'b0;
    dest = '0;
    case (dec.kind)
      CF_BEQ: begin take = eq;   dest = branch_dest(slot_addr, dec.offs); end
      CF_BNE: begin take = !eq;  dest = branch_dest(slot_addr, dec.offs); end
      CF_J:   begin take = 1'b1; dest = jump_dest(slot_addr, dec.index); end
      CF_JR:  begin take = 1'b1; dest = reg_val; end
      default: ;
    endcase
  end
endmodule

// File: rtl/pcseq_state.sv
module pcseq_state
  import pcseq_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [WORD_W-1:0] pc_next,
  input  logic              slot_next,
  input  logic              load_next,
  output logic [WORD_W-1:0] pc,
  output logic [WORD_W-1:0] dec_pc,
  output logic              dec_valid,
  output logic              in_slot,
  output logic              after_load
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc         <= RESET_ADDR;
      dec_pc     <= RESET_ADDR;
      dec_valid  <= 1'b0;
      in_slot    <= 1'b0;
      after_load <= 1'b0;
    end else if (!hold) begin
      pc         <= pc_next;
      dec_pc     <= pc;
      dec_valid  <= 1'b1;
      in_slot    <= slot_next;
      after_load <= load_next;
    end
  end
endmodule

// File: rtl/delay_slot_sequencer.sv
module delay_slot_sequencer
  import pcseq_pkg::*;
#(
  parameter logic [31:0] RESET_ADDR = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stall,
  input  logic [31:0] instr_word,
  input  logic        rs_equal,
  input  logic [31:0] rs_value,
  output logic [31:0] fetch_addr,
  output logic [31:0] decode_addr,
  output logic        decode_in_slot,
  output logic        redirect,
  output logic        slot_error,
  output logic        load_shadow
);
  localparam logic [WORD_W-1:0] STEP = WORD_W'(4);

  dec_t              dec;
  logic              take_w;
  logic [WORD_W-1:0] tgt_addr;
  logic [WORD_W-1:0] slot_addr;
  logic [WORD_W-1:0] pc_q, dec_pc_q, pc_next;
  logic              dec_valid_q, in_slot_q, after_load_q;
  logic              advance, is_cti, slot_next, load_next;

  pcseq_decode u_dec (.word(instr_word), .dec(dec));

  assign slot_addr = dec_pc_q + STEP;

  pcseq_target u_tgt (
    .dec(dec), .eq(rs_equal), .reg_val(rs_value),
    .slot_addr(slot_addr), .take(take_w), .dest(tgt_addr)
  );

  assign advance    = dec_valid_q && !stall;
  assign is_cti     = (dec.kind != CF_NONE);
  assign redirect   = advance && take_w && !in_slot_q;
  assign slot_error = advance && is_cti && in_slot_q;
  assign pc_next    = redirect ? tgt_addr : pc_q + STEP;
  assign slot_next  = dec_valid_q && is_cti && !in_slot_q;
  assign load_next  = dec_valid_q && dec.is_load;

  pcseq_state #(.RESET_ADDR(RESET_ADDR)) u_st (
    .clk(clk), .rst_n(rst_n), .hold(stall),
    .pc_next(pc_next), .slot_next(slot_next), .load_next(load_next),
    .pc(pc_q), .dec_pc(dec_pc_q), .dec_valid(dec_valid_q),
    .in_slot(in_slot_q), .after_load(after_load_q)
  );

  assign fetch_addr     = pc_q;
  assign decode_addr    = dec_pc_q;
  assign decode_in_slot = dec_valid_q && in_slot_q;
  assign load_shadow    = dec_valid_q && after_load_q;
endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        stall,
  input logic [31:0] fetch_addr,
  input logic [31:0] decode_addr,
  input logic        redirect,
  input logic        slot_error,
  input logic        decode_in_slot,
  input logic [31:0] tgt_addr
);
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(fetch_addr) && $stable(decode_addr))); // R8
  AST_STALL_NO_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !redirect); // R8
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !redirect) |=> fetch_addr == $past(fetch_addr) + 32'd4); // R2
  AST_REDIR_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> fetch_addr == $past(tgt_addr)); // R3
  AST_SLOT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (decode_in_slot && decode_addr == $past(fetch_addr))); // R5
  AST_ERR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    slot_error |-> (!redirect && decode_in_slot)); // R9
endmodule

bind delay_slot_sequencer pcseq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .fetch_addr(fetch_addr),
  .decode_addr(decode_addr), .redirect(redirect), .slot_error(slot_error),
  .decode_in_slot(decode_in_slot), .tgt_addr(tgt_addr)
);

// File: tb/delay_slot_sequencer_bench.sv
`timescale 1ns/1ps
module delay_slot_sequencer_bench;
  localparam logic [31:0] BASE = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0;
  logic [31:0] instr_q;
  logic        rs_equal = 1'b0;
  logic [31:0] rs_value = '0;
  logic [31:0] fetch_addr, decode_addr;
  logic        decode_in_slot, redirect, slot_error, load_shadow;
  logic [31:0] prog [0:63];
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  delay_slot_sequencer #(.RESET_ADDR(BASE)) u_delay_slot_sequencer (
    .clk(clk), .rst_n(rst_n), .stall(stall), .instr_word(instr_q),
    .rs_equal(rs_equal), .rs_value(rs_value), .fetch_addr(fetch_addr),
    .decode_addr(decode_addr), .decode_in_slot(decode_in_slot),
    .redirect(redirect), .slot_error(slot_error), .load_shadow(load_shadow)
  );

  function automatic logic [31:0] mem_read(input logic [31:0] a);
    logic [31:0] off = a - BASE;
    return (off < 32'd256) ? prog[off[7:2]] : 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) instr_q <= '0;
    else if (!stall) instr_q <= mem_read(fetch_addr);
  end

  function automatic logic [31:0] rel_dest(input logic [31:0] br_at, input logic [15:0] imm);
    int signed delta = $signed(imm) * 4;
    return br_at + 32'd4 + 32'(delta);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic clear_prog;
    for (int i = 0; i < 64; i++) prog[i] = 32'h0;
  endtask

  task automatic restart;
    rst_n = 1'b0; stall = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    clear_prog();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 fetch", fetch_addr, BASE);
    check("R1 flags", {28'h0, redirect, slot_error, decode_in_slot, load_shadow}, 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_sequential;
    clear_prog(); restart();
    for (int k = 1; k <= 6; k++) begin
      step();
      check("R2 seq", fetch_addr, BASE + 32'(4 * k));
    end
  endtask

  task automatic t_beq(input logic eq);
    clear_prog(); prog[0] = 32'h1000_0003; rs_equal = eq; restart();
    step();
    check("R3 beq redirect", {31'h0, redirect}, {31'h0, eq});
    step();
    check("R5 slot decoded", {31'h0, decode_in_slot}, 32'h1);
    check("R5 slot addr", decode_addr, BASE + 32'd4);
    check("R3 beq fetch", fetch_addr, eq ? rel_dest(BASE, 16'h0003) : BASE + 32'd8);
  endtask

  task automatic t_bne(input logic eq);
    clear_prog(); prog[11] = 32'h1500_fff7; rs_equal = eq; restart();
    step(12);
    check("R4 bne addr", decode_addr, 32'h0040_002c);
    check("R4 bne redirect", {31'h0, redirect}, {31'h0, !eq});
    step();
    check("R4 bne fetch", fetch_addr, eq ? 32'h0040_0034 : 32'h0040_000c);
  endtask

  task automatic t_jump;
    clear_prog(); prog[0] = 32'h0810_0010; rs_equal = 1'b0; restart();
    step(2);
    check("R6 jump fetch", fetch_addr, 32'h0040_0040);
  endtask

  task automatic t_regjump;
    clear_prog(); prog[0] = 32'h03e0_0008; rs_value = 32'h0040_0080; restart();
    step();
    check("R7 jr redirect", {31'h0, redirect}, 32'h1);
    step();
    check("R7 jr fetch", fetch_addr, 32'h0040_0080);
  endtask

  task automatic t_stall;
    clear_prog(); prog[3] = 32'h1000_0004; rs_equal = 1'b1; restart();
    step(4);
    check("R8 pre-stall redirect", {31'h0, redirect}, 32'h1);
    stall = 1'b1;
    step(3);
    check("R8 fetch held", fetch_addr, BASE + 32'd16);
    check("R8 decode held", decode_addr, BASE + 32'd12);
    check("R8 no redirect", {31'h0, redirect}, 32'h0);
    stall = 1'b0;
    step();
    check("R8 resume fetch", fetch_addr, rel_dest(BASE + 32'd12, 16'h0004));
  endtask

  task automatic t_slot_branch;
    clear_prog(); prog[0] = 32'h1000_0008; prog[1] = 32'h1000_0002; rs_equal = 1'b1; restart();
    step(2);
    check("R9 error", {31'h0, slot_error}, 32'h1);
    check("R9 no redirect", {31'h0, redirect}, 32'h0);
    check("R9 first target", fetch_addr, rel_dest(BASE, 16'h0008));
    step();
    check("R9 ignored", fetch_addr, rel_dest(BASE, 16'h0008) + 32'd4);
    check("R9 error clears", {31'h0, slot_error}, 32'h0);
  endtask

  task automatic t_load;
    clear_prog(); prog[0] = 32'h8c01_0000; rs_equal = 1'b0; restart();
    step();
    check("R10 load itself", {31'h0, load_shadow}, 32'h0);
    step();
    check("R10 shadow", {31'h0, load_shadow}, 32'h1);
    step();
    check("R10 shadow ends", {31'h0, load_shadow}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_sequential();
    t_beq(1'b1);
    t_beq(1'b0);
    t_bne(1'b0);
    t_bne(1'b1);
    t_jump();
    t_regjump();
    t_stall();
    t_slot_branch();
    t_load();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule